// File: doc/BRIEF.md
# Software Interrupt Set/Clear Mapper

This block keeps a small vector of interrupt bits that software raises and lowers by itself. Raising and lowering go through two separate write-one registers, so no read-modify-write is needed: a 1 in the written word acts on that bit and a 0 leaves it alone. Reading either of the two registers returns the live vector.

Each software bit has its own enable and its own 5-bit destination field. An enabled, pending bit drives the output line its destination names. Lines with several such bits are the OR of them. The 24-bit output vector goes on to be merged with interrupts that come from hardware. Configuration and the vector are reached through a simple word-addressed register bus with one-cycle read latency.

The register bus has no handshake and holds no state apart from the read data register. For that reason the block has no sequencing state machine. Its state is the pending vector, the enable word and the destination fields.

Top module: `swi_mapper`

## Requirements
- R1: After reset the pending vector, the enable word and every destination field are zero, `irq_out` is zero, and every register reads zero.
- R2: A write to word 0x105 (the raise register) sets each pending bit i for which write-data bit i is 1. Bits written as 0 keep their value.
- R3: A write to word 0x106 (the lower register) clears each pending bit i for which write-data bit i is 1. Bits written as 0 keep their value.
- R4: A read of word 0x105 or word 0x106 returns the pending vector in bits 15:0, with bits 31:16 zero.
- R5: Word 0x100 holds the enable of software bit i in bit i (bits 15:0). It is written as a whole and reads back with bits 31:16 zero.
- R6: Words 0x101 to 0x104 are the destination registers. Register k (word 0x101+k) holds the destinations of bits 4k..4k+3 at bit positions 4:0, 12:8, 20:16 and 28:24, lowest-numbered bit first. All other bit positions read zero.
- R7: Output line o is 1 exactly when at least one bit is pending, enabled, and has destination o. Lines that share a destination are ORed.
- R8: A disabled bit keeps its pending state and drives no output. Enabling it again makes it drive its destination.
- R9: A destination value of 24 to 31 drives no output line.
- R10: Read data appears in the cycle after the read strobe. Any word outside 0x100..0x106 reads zero, and a write to such a word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_rd_en | input | 1 | Read strobe for one cycle |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| irq_out | output | 24 | Routed software interrupt vector |

## Verification
The bench builds the block with its defaults: 16 software bits, 24 output lines and 5-bit destination fields. This puts both the full output range and the eight unreachable destinations 24 to 31 within reach, together with all four destination registers. With 16 bits and 24 lines, the bench can stack three bits on one line to exercise the OR, and it can also spread bits over the lowest and highest lines. A behavioural model predicts `irq_out` after every bus cycle and the value of every read.

// File: rtl/swi_pkg.sv
package swi_pkg;

    // Word addresses of the register window
    localparam int unsigned ENABLE_WORD   = 'h100;
    localparam int unsigned MAP_BASE_WORD = 'h101;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_MAP,
        SEL_RAISE,
        SEL_LOWER
    } swi_sel_e;

endpackage

// File: rtl/swi_decode.sv
module swi_decode
    import swi_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int MAP_REGS   = 4,
    parameter int MAP_IDX_W  = 2,
    parameter int RAISE_WORD = 'h105,
    parameter int LOWER_WORD = 'h106
) (
    input  logic [ADDR_W-1:0]    addr,
    output swi_sel_e             sel,
    output logic [MAP_IDX_W-1:0] map_idx
);

    always_comb begin
        sel     = SEL_NONE;
        map_idx = '0;
        if (addr == ADDR_W'(ENABLE_WORD)) begin
            sel = SEL_ENABLE;
        end else if ((addr >= ADDR_W'(MAP_BASE_WORD)) &&
                     (addr <  ADDR_W'(MAP_BASE_WORD + MAP_REGS))) begin
            sel     = SEL_MAP;
            map_idx = MAP_IDX_W'(addr - ADDR_W'(MAP_BASE_WORD));
        end else if (addr == ADDR_W'(RAISE_WORD)) begin
            sel = SEL_RAISE;
        end else if (addr == ADDR_W'(LOWER_WORD)) begin
            sel = SEL_LOWER;
        end
    end

endmodule

// File: rtl/swi_config.sv
module swi_config
    import swi_pkg::*;
#(
    parameter int NUM_SWI   = 16,
    parameter int DEST_W    = 5,
    parameter int DATA_W    = 32,
    parameter int FIELDS    = 4,
    parameter int STRIDE    = 8,
    parameter int MAP_REGS  = 4,
    parameter int MAP_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  swi_sel_e             sel,
    input  logic [MAP_IDX_W-1:0] map_idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_SWI-1:0]   en,
    output logic [DEST_W-1:0]    dest [NUM_SWI],
    output logic [DATA_W-1:0]    map_word
);

    logic [DATA_W-1:0] map_words [MAP_REGS];
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_en && (sel == SEL_ENABLE)) begin
            en <= wdata[NUM_SWI-1:0];
        end
    end

    // One destination field per software bit
    for (genvar i = 0; i < NUM_SWI; i++) begin : g_dest
        localparam int REG_IDX = i / FIELDS;
        localparam int FLD     = i % FIELDS;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dest[i] <= '0;
            end else if (wr_en && (sel == SEL_MAP) &&
                         (map_idx == MAP_IDX_W'(REG_IDX))) begin
                dest[i] <= wdata[FLD*STRIDE +: DEST_W];
            end
        end
    end

    // Readback words, packed with zero padding
    for (genvar r = 0; r < MAP_REGS; r++) begin : g_word
        for (genvar f = 0; f < FIELDS; f++) begin : g_fld
            if (r*FIELDS + f < NUM_SWI) begin : g_used
                assign map_words[r][f*STRIDE +: DEST_W]          = dest[r*FIELDS + f];
                assign map_words[r][f*STRIDE+DEST_W +: STRIDE-DEST_W] = '0;
            end else begin : g_spare
                assign map_words[r][f*STRIDE +: STRIDE] = '0;
            end
        end
        if (FIELDS*STRIDE < DATA_W) begin : g_top
            assign map_words[r][DATA_W-1:FIELDS*STRIDE] = '0;
        end
    end

    assign map_word = map_words[map_idx];

endmodule

// File: rtl/swi_pending.sv
module swi_pending
    import swi_pkg::*;
#(
    parameter int NUM_SWI = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  swi_sel_e           sel,
    input  logic [NUM_SWI-1:0] wbits,
    output logic [NUM_SWI-1:0] vec
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_RAISE: vec <= vec | wbits;
                SEL_LOWER: vec <= vec & ~wbits;
                default:   vec <= vec;
            endcase
        end
    end

endmodule

// File: rtl/swi_router.sv
module swi_router #(
    parameter int NUM_SWI = 16,
    parameter int NUM_OUT = 24,
    parameter int DEST_W  = 5
) (
    input  logic [NUM_SWI-1:0] vec,
    input  logic [NUM_SWI-1:0] en,
    input  logic [DEST_W-1:0]  dest [NUM_SWI],
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_SWI-1:0]                live;
    logic [NUM_OUT-1:0][NUM_SWI-1:0]   hit;

    assign live = vec & en;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        for (genvar i = 0; i < NUM_SWI; i++) begin : g_in
            assign hit[o][i] = live[i] && (dest[i] == DEST_W'(o));
        end
        assign irq_out[o] = |hit[o];
    end

endmodule

// File: rtl/swi_mapper.sv
module swi_mapper
    import swi_pkg::*;
#(
    parameter int NUM_SWI = 16,
    parameter int NUM_OUT = 24,
    parameter int DEST_W  = 5,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    localparam int STRIDE     = 8;
    localparam int FIELDS     = DATA_W / STRIDE;
    localparam int MAP_REGS   = (NUM_SWI + FIELDS - 1) / FIELDS;
    localparam int MAP_IDX_W  = (MAP_REGS > 1) ? $clog2(MAP_REGS) : 1;
    localparam int RAISE_WORD = MAP_BASE_WORD + MAP_REGS;
    localparam int LOWER_WORD = RAISE_WORD + 1;

    swi_sel_e              sel;
    logic [MAP_IDX_W-1:0]  map_idx;
    logic [NUM_SWI-1:0]    swi_en;
    logic [NUM_SWI-1:0]    swi_vec;
    logic [DEST_W-1:0]     swi_dest [NUM_SWI];
    logic [DATA_W-1:0]     map_word;
    logic [DATA_W-1:0]     rd_next;

    swi_decode #(
        .ADDR_W(ADDR_W), .MAP_REGS(MAP_REGS), .MAP_IDX_W(MAP_IDX_W),
        .RAISE_WORD(RAISE_WORD), .LOWER_WORD(LOWER_WORD)
    ) u_decode (
        .addr(reg_addr), .sel(sel), .map_idx(map_idx)
    );

    swi_config #(
        .NUM_SWI(NUM_SWI), .DEST_W(DEST_W), .DATA_W(DATA_W), .FIELDS(FIELDS),
        .STRIDE(STRIDE), .MAP_REGS(MAP_REGS), .MAP_IDX_W(MAP_IDX_W)
    ) u_config (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(sel),
        .map_idx(map_idx), .wdata(reg_wdata),
        .en(swi_en), .dest(swi_dest), .map_word(map_word)
    );

    swi_pending #(
        .NUM_SWI(NUM_SWI)
    ) u_pending (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(sel),
        .wbits(reg_wdata[NUM_SWI-1:0]), .vec(swi_vec)
    );

    swi_router #(
        .NUM_SWI(NUM_SWI), .NUM_OUT(NUM_OUT), .DEST_W(DEST_W)
    ) u_router (
        .vec(swi_vec), .en(swi_en), .dest(swi_dest), .irq_out(irq_out)
    );

    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_ENABLE: rd_next[NUM_SWI-1:0] = swi_en;
            SEL_MAP:    rd_next = map_word;
            SEL_RAISE:  rd_next[NUM_SWI-1:0] = swi_vec;
            SEL_LOWER:  rd_next[NUM_SWI-1:0] = swi_vec;
            SEL_NONE:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            reg_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/swi_mapper_chk.sv
module swi_mapper_chk #(
    parameter int NUM_SWI    = 16,
    parameter int NUM_OUT    = 24,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LO_WORD    = 'h100,
    parameter int RAISE_WORD = 'h105,
    parameter int LOWER_WORD = 'h106
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [NUM_SWI-1:0] vec,
    input logic [NUM_SWI-1:0] en
);

    logic wr_raise, wr_lower, rd_outside;
    assign wr_raise   = reg_wr_en && (reg_addr == ADDR_W'(RAISE_WORD));
    assign wr_lower   = reg_wr_en && (reg_addr == ADDR_W'(LOWER_WORD));
    assign rd_outside = reg_rd_en && ((reg_addr < ADDR_W'(LO_WORD)) ||
                                      (reg_addr > ADDR_W'(LOWER_WORD)));

    // R2
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_raise |=> ((vec & $past(reg_wdata[NUM_SWI-1:0])) == $past(reg_wdata[NUM_SWI-1:0])));

    // R3
    lower_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lower |=> ((vec & $past(reg_wdata[NUM_SWI-1:0])) == '0));

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_raise || wr_lower) |=> $stable(vec));

    // R7
    idle_vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) |-> (irq_out == '0));

    // R8
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (irq_out == '0));

    // R10
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_outside |=> (reg_rdata == '0));

endmodule

bind swi_mapper swi_mapper_chk #(
    .NUM_SWI(NUM_SWI), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LO_WORD(swi_pkg::ENABLE_WORD), .RAISE_WORD(RAISE_WORD), .LOWER_WORD(LOWER_WORD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .vec(swi_vec), .en(swi_en)
);

// File: tb/tb_swi_mapper.sv
module tb_swi_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // behavioural model
    logic [15:0] m_vec = '0;
    logic [15:0] m_en  = '0;
    int          m_dest [16];

    swi_mapper dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] m_out();
        logic [23:0] o = '0;
        for (int i = 0; i < 16; i++)
            if (m_vec[i] && m_en[i] && m_dest[i] < 24) o[m_dest[i]] = 1'b1;
        return o;
    endfunction

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic [31:0] w = '0;
        if (a == 10'h100) w[15:0] = m_en;
        else if (a >= 10'h101 && a <= 10'h104) begin
            for (int f = 0; f < 4; f++) w[f*8 +: 5] = 5'(m_dest[(a - 10'h101)*4 + f]);
        end else if (a == 10'h105 || a == 10'h106) w[15:0] = m_vec;
        return w;
    endfunction

    task automatic m_write(input logic [9:0] a, input logic [31:0] d);
        if (a == 10'h100) m_en = d[15:0];
        else if (a >= 10'h101 && a <= 10'h104) begin
            for (int f = 0; f < 4; f++) m_dest[(a - 10'h101)*4 + f] = int'(d[f*8 +: 5]);
        end else if (a == 10'h105) m_vec = m_vec | d[15:0];
        else if (a == 10'h106) m_vec = m_vec & ~d[15:0];
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_write(a, d);
        chk({cur_tag, " irq_out"}, 32'(irq_out), 32'(m_out()));
    endtask

    task automatic bus_rd(input logic [9:0] a, input string tag);
        logic [31:0] exp;
        exp = m_read(a);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk(tag, reg_rdata, exp);
        chk({cur_tag, " irq_out"}, 32'(irq_out), 32'(m_out()));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 16; i++) m_dest[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_tag = "R1";
        chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
        for (int a = 'h100; a <= 'h106; a++) bus_rd(10'(a), "R1 reset readback");

        // R5 enable register
        cur_tag = "R5";
        bus_wr(10'h100, 32'h1234_ABCD);
        bus_rd(10'h100, "R5 enable readback");
        bus_wr(10'h100, 32'h0000_FFFF);

        // R6 destination registers, padding bits read zero
        cur_tag = "R6";
        bus_wr(10'h101, 32'hFFFF_FFFF);
        bus_rd(10'h101, "R6 map padding");
        bus_wr(10'h101, 32'h0302_0100);           // bits 0..3 -> lines 0..3
        bus_wr(10'h102, 32'h1805_1717);           // bits 4,5 -> 23; 6 -> 5; 7 -> 24
        bus_wr(10'h103, 32'h0707_071F);           // bit 8 -> 31; 9,10,11 -> 7
        bus_wr(10'h104, 32'h0D0C_0B0A);           // bits 12..15 -> 10..13
        for (int a = 'h101; a <= 'h104; a++) bus_rd(10'(a), "R6 map readback");

        // R2 raise, zeros have no effect
        cur_tag = "R2";
        bus_wr(10'h105, 32'h0000_0005);
        bus_rd(10'h105, "R2 raise readback");
        bus_wr(10'h105, 32'h0000_0000);
        bus_rd(10'h105, "R2 zero write keeps vector");
        bus_wr(10'h105, 32'hFFFF_0070);

        // R4 both registers read the live vector
        cur_tag = "R4";
        bus_rd(10'h105, "R4 raise word reads vector");
        bus_rd(10'h106, "R4 lower word reads vector");

        // R3 lower
        cur_tag = "R3";
        bus_wr(10'h106, 32'h0000_0004);
        bus_rd(10'h106, "R3 lower readback");
        bus_wr(10'h106, 32'h0000_0000);
        bus_rd(10'h106, "R3 zero write keeps vector");

        // R7 OR of bits 9,10,11 on line 7
        cur_tag = "R7";
        bus_wr(10'h105, 32'h0000_0E00);
        chk("R7 shared line high", 32'(irq_out[7]), 32'h1);
        bus_wr(10'h106, 32'h0000_0200);
        chk("R7 shared line still high", 32'(irq_out[7]), 32'h1);
        bus_wr(10'h106, 32'h0000_0400);
        chk("R7 shared line still high", 32'(irq_out[7]), 32'h1);
        bus_wr(10'h106, 32'h0000_0800);
        chk("R7 shared line low", 32'(irq_out[7]), 32'h0);

        // R9 destinations 24 and 31
        cur_tag = "R9";
        bus_wr(10'h106, 32'h0000_FFFF);
        bus_wr(10'h105, 32'h0000_0180);
        chk("R9 out-of-range destinations", 32'(irq_out), 32'h0);
        bus_rd(10'h105, "R9 bits stay pending");

        // R8 disable keeps state
        cur_tag = "R8";
        bus_wr(10'h105, 32'h0000_F00F);
        bus_wr(10'h100, 32'h0000_0000);
        chk("R8 disabled drives nothing", 32'(irq_out), 32'h0);
        bus_rd(10'h105, "R8 state kept while disabled");
        bus_wr(10'h100, 32'h0000_FFFF);
        chk("R8 re-enabled lines", 32'(irq_out), 32'h0000_3C0F);

        // R10 outside words
        cur_tag = "R10";
        bus_wr(10'h107, 32'hFFFF_FFFF);
        bus_wr(10'h0FF, 32'hFFFF_FFFF);
        bus_wr(10'h000, 32'hFFFF_FFFF);
        bus_rd(10'h107, "R10 outside read zero");
        bus_rd(10'h0FF, "R10 outside read zero");
        bus_rd(10'h100, "R10 enable untouched");
        bus_rd(10'h106, "R10 vector untouched");

        // R7 mixed traffic
        cur_tag = "R7";
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 60; n++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            case (lf[31:29])
                3'd0:    bus_wr(10'h100, lf);
                3'd1:    bus_wr(10'(10'h101 + lf[3:2]), lf);
                3'd2, 3'd3: bus_wr(10'h105, lf);
                3'd4, 3'd5: bus_wr(10'h106, lf);
                default: bus_rd(10'(10'h100 + (lf[7:4] % 7)), "R7 mixed readback");
            endcase
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule